// File: doc/BRIEF.md
# Last-Gasp Commit Sequencer

This block orders the final logging actions after the supply starts to fail. A filtered, active-low power-fail input latches the event. The block then closes the ingest path into the buffer and drains the buffer into storage. After the drain it asks the record framer for one final commit marker. While this runs it records the sequence number at which ingest stopped and the sequence number that was last committed. It also measures how many cycles the drain took and how many the commit took. These figures let the hold-up capacitance be checked against the real flush-plus-commit time.

A deadline window opens when the event is latched. If the commit marker is not confirmed inside that window, the commit is abandoned and a missed flag is raised. The last-committed value then keeps the previous commit point, so replay after the next boot rolls back to it. In normal running the framer reports its routine batch commits on the same done line, and each report moves the last-committed point forward. The final state holds the recovery view until reset. Only reset returns the block to normal running.

Top module: `pf_commit_seq`

## Requirements
- R1: After reset, `state` is 0 (normal running), `ingest_en` is 1, `drain_req`, `commit_req`, `pf_latched` and `commit_missed` are 0, and all sequence, stamp and duration outputs are 0.
- R2: `pf_n` passes through two synchronizing flops and must stay low for GLITCH_CYC (default 4) consecutive synchronized samples. A low pulse of GLITCH_CYC-1 cycles leaves the block in normal running. A sustained low that is first sampled on edge 1 enters the detect state on edge GLITCH_CYC+3.
- R3: After the event, the states run in a fixed order with these `state` codes: running 0, then detect 1 (one cycle), then freeze 2 (one cycle), then flush 3, then commit 4, then recover 5. `ingest_en` is low in every state except running.
- R4: `freeze_seq` takes the value of `cur_seq` during the freeze cycle. Later changes of `cur_seq` have no effect on it.
- R5: In the flush state `drain_req` is high until `buf_empty` is sampled high, and the block then moves to commit. `t_flush` equals the number of clock cycles spent in flush.
- R6: In the commit state `commit_req` is high until `commit_done` is sampled high. The block then moves to recover with `last_commit_seq` equal to `freeze_seq`. `t_commit` equals the number of cycles spent in commit.
- R7: The deadline window is DEADLINE_CYC cycles (default 64), counted from the detect cycle. If the commit is not confirmed, `state` becomes 5 exactly DEADLINE_CYC edges after detect is entered. At that point `commit_missed` is set, `last_commit_seq` keeps its previous value, and both requests drop.
- R8: In normal running, a `commit_done` pulse loads `last_commit_seq` with `cur_seq`. A `commit_done` seen in the detect, freeze or flush state has no effect.
- R9: `pf_stamp` equals the number of clock edges with reset low that occur before the edge that enters detect.
- R10: Once latched, the event is kept even if `pf_n` returns high. `pf_latched` stays 1 and state 5 holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_n | input | 1 | Asynchronous power-fail input, active low |
| cur_seq | input | SEQ_W | Current record sequence number |
| buf_empty | input | 1 | Buffer reports no queued or in-flight data |
| commit_done | input | 1 | Framer confirms a commit marker write |
| ingest_en | output | 1 | Allows new writes into the buffer |
| drain_req | output | 1 | Asks the buffer to drain to storage |
| commit_req | output | 1 | Asks the framer for the final commit marker |
| state | output | 3 | Sequencer state code |
| pf_latched | output | 1 | Power-fail event latched |
| commit_missed | output | 1 | Deadline expired before the commit was confirmed |
| freeze_seq | output | SEQ_W | Sequence captured when ingest stopped |
| last_commit_seq | output | SEQ_W | Last committed sequence, the replay point |
| pf_stamp | output | TIME_W | Time counter value at the detect event |
| t_flush | output | DUR_W | Cycles spent in flush |
| t_commit | output | DUR_W | Cycles spent in commit |

## Verification
On every cycle the assertions check the following. Ingest stays closed once the event is latched. Freeze is entered only from detect. A commit request only ever follows an empty buffer. A successful finish leaves the last-committed point equal to the freeze sequence, and a missed deadline leaves that point unchanged. The freeze sequence moves only out of the freeze cycle, and the latch and the recover state are both sticky.

Several behaviours can only be shown by the bench's scenarios: the exact latch latency and the rejection of short glitches, the measured flush and commit durations, the timestamp value, and the exact edge at which the deadline expires.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_PF_DETECT = 3'd1,
        ST_FREEZE    = 3'd2,
        ST_FLUSH     = 3'd3,
        ST_COMMIT    = 3'd4,
        ST_RECOVER   = 3'd5
    } pf_state_e;

    // True while the last-gasp window is open.
    function automatic logic in_window(pf_state_e s);
        return (s == ST_PF_DETECT) || (s == ST_FREEZE) ||
               (s == ST_FLUSH) || (s == ST_COMMIT);
    endfunction

endpackage

// File: rtl/pf_glitch_filter.sv
module pf_glitch_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pf_n,
    output logic hit
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            low_cnt <= '0;
        end else begin
            s1 <= pf_n;
            s2 <= s1;
            if (s2)
                low_cnt <= '0;
            else if (low_cnt != CW'(GLITCH_CYC))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign hit = (low_cnt == CW'(GLITCH_CYC));
endmodule

// File: rtl/pf_dur_meter.sv
module pf_dur_meter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (en && (count != {W{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pf_commit_seq.sv
module pf_commit_seq
    import pf_seq_pkg::*;
#(
    parameter int SEQ_W        = 16,
    parameter int TIME_W       = 32,
    parameter int DUR_W        = 16,
    parameter int GLITCH_CYC   = 4,
    parameter int DEADLINE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_n,
    input  logic [SEQ_W-1:0]  cur_seq,
    input  logic              buf_empty,
    input  logic              commit_done,
    output logic              ingest_en,
    output logic              drain_req,
    output logic              commit_req,
    output logic [2:0]        state,
    output logic              pf_latched,
    output logic              commit_missed,
    output logic [SEQ_W-1:0]  freeze_seq,
    output logic [SEQ_W-1:0]  last_commit_seq,
    output logic [TIME_W-1:0] pf_stamp,
    output logic [DUR_W-1:0]  t_flush,
    output logic [DUR_W-1:0]  t_commit
);
    localparam int DL_W = $clog2(DEADLINE_CYC + 1);

    pf_state_e         st;
    logic              pf_hit;
    logic [TIME_W-1:0] time_now;
    logic [DL_W-1:0]   dl_cnt;
    logic              dl_expire;

    pf_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk(clk), .rst(rst), .pf_n(pf_n), .hit(pf_hit)
    );

    pf_dur_meter #(.W(TIME_W)) u_time (
        .clk(clk), .rst(rst), .en(1'b1), .count(time_now)
    );

    pf_dur_meter #(.W(DUR_W)) u_flush_meter (
        .clk(clk), .rst(rst), .en(st == ST_FLUSH), .count(t_flush)
    );

    pf_dur_meter #(.W(DUR_W)) u_commit_meter (
        .clk(clk), .rst(rst), .en(st == ST_COMMIT), .count(t_commit)
    );

    assign dl_expire = (dl_cnt == DL_W'(DEADLINE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st              <= ST_RUN;
            pf_latched      <= 1'b0;
            commit_missed   <= 1'b0;
            freeze_seq      <= '0;
            last_commit_seq <= '0;
            pf_stamp        <= '0;
            dl_cnt          <= '0;
        end else if (st == ST_RUN) begin
            if (commit_done)
                last_commit_seq <= cur_seq;
            if (pf_hit) begin
                st         <= ST_PF_DETECT;
                pf_latched <= 1'b1;
                pf_stamp   <= time_now;
                dl_cnt     <= '0;
            end
        end else if (in_window(st)) begin
            dl_cnt <= dl_cnt + 1'b1;
            if (st == ST_FREEZE)
                freeze_seq <= cur_seq;
            if ((st == ST_COMMIT) && commit_done) begin
                last_commit_seq <= freeze_seq;
                st              <= ST_RECOVER;
            end else if (dl_expire) begin
                commit_missed <= 1'b1;
                st            <= ST_RECOVER;
            end else begin
                case (st)
                    ST_PF_DETECT: st <= ST_FREEZE;
                    ST_FREEZE:    st <= ST_FLUSH;
                    ST_FLUSH:     if (buf_empty) st <= ST_COMMIT;
                    default:      st <= st;
                endcase
            end
        end
    end

    assign ingest_en  = (st == ST_RUN);
    assign drain_req  = (st == ST_FLUSH);
    assign commit_req = (st == ST_COMMIT);
    assign state      = st;
endmodule

// File: rtl/pf_commit_seq_chk.sv
module pf_commit_seq_chk #(
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             buf_empty,
    input logic             ingest_en,
    input logic             commit_req,
    input logic [2:0]       state,
    input logic             pf_latched,
    input logic             commit_missed,
    input logic [SEQ_W-1:0] freeze_seq,
    input logic [SEQ_W-1:0] last_commit_seq
);
    import pf_seq_pkg::*;

    p_ingest_closed_r3: assert property (@(posedge clk) disable iff (rst)
        pf_latched |-> !ingest_en);

    p_freeze_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state == 3'(ST_FREEZE)) |-> ($past(state) == 3'(ST_PF_DETECT)));

    p_freeze_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state != 3'(ST_FREEZE)) |=> $stable(freeze_seq));

    p_commit_after_empty_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(commit_req) |-> $past(buf_empty));

    p_commit_point_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(state == 3'(ST_RECOVER)) && !commit_missed) |-> (last_commit_seq == freeze_seq));

    p_miss_rollback_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(commit_missed) |-> $stable(last_commit_seq));

    p_recover_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (state == 3'(ST_RECOVER)) |=> (state == 3'(ST_RECOVER)));

    p_latch_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        pf_latched |=> pf_latched);
endmodule

bind pf_commit_seq pf_commit_seq_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst(rst), .buf_empty(buf_empty), .ingest_en(ingest_en),
    .commit_req(commit_req), .state(state), .pf_latched(pf_latched),
    .commit_missed(commit_missed), .freeze_seq(freeze_seq),
    .last_commit_seq(last_commit_seq)
);

// File: tb/pf_commit_seq_bench.sv
module pf_commit_seq_bench;
    localparam int SEQ_W = 16, TIME_W = 32, DUR_W = 16;
    localparam int G = 4, DL = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pf_n = 1'b1;
    logic [SEQ_W-1:0]  cur_seq = '0;
    logic              buf_empty = 1'b0;
    logic              commit_done = 1'b0;
    logic              ingest_en, drain_req, commit_req, pf_latched, commit_missed;
    logic [2:0]        state;
    logic [SEQ_W-1:0]  freeze_seq, last_commit_seq;
    logic [TIME_W-1:0] pf_stamp;
    logic [DUR_W-1:0]  t_flush, t_commit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    pf_commit_seq #(.SEQ_W(SEQ_W), .TIME_W(TIME_W), .DUR_W(DUR_W),
                    .GLITCH_CYC(G), .DEADLINE_CYC(DL)) u_pf_commit_seq (
        .clk(clk), .rst(rst), .pf_n(pf_n), .cur_seq(cur_seq),
        .buf_empty(buf_empty), .commit_done(commit_done),
        .ingest_en(ingest_en), .drain_req(drain_req), .commit_req(commit_req),
        .state(state), .pf_latched(pf_latched), .commit_missed(commit_missed),
        .freeze_seq(freeze_seq), .last_commit_seq(last_commit_seq),
        .pf_stamp(pf_stamp), .t_flush(t_flush), .t_commit(t_commit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pf_n = 1'b1; buf_empty = 1'b0; commit_done = 1'b0; cur_seq = '0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic routine_commit(input logic [SEQ_W-1:0] s);
        cur_seq = s; commit_done = 1'b1;
        tick(1);
        commit_done = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 state", 32'(state), 0);
        chk("R1 ingest_en", 32'(ingest_en), 1);
        chk("R1 drain_req", 32'(drain_req), 0);
        chk("R1 commit_req", 32'(commit_req), 0);
        chk("R1 pf_latched", 32'(pf_latched), 0);
        chk("R1 commit_missed", 32'(commit_missed), 0);
        chk("R1 last_commit_seq", 32'(last_commit_seq), 0);
        chk("R1 t_flush", 32'(t_flush), 0);
    endtask

    task automatic t_glitch_reject();
        do_reset();
        pf_n = 1'b0;
        tick(G - 1);
        pf_n = 1'b1;
        tick(10);
        chk("R2 short glitch state", 32'(state), 0);
        chk("R2 short glitch latch", 32'(pf_latched), 0);
        chk("R2 short glitch ingest", 32'(ingest_en), 1);
    endtask

    task automatic t_full_sequence();
        do_reset();
        routine_commit(16'd10);
        chk("R8 routine commit", 32'(last_commit_seq), 10);
        cur_seq = 16'd25;
        pf_n = 1'b0;
        tick(G + 2);
        chk("R2 not yet latched", 32'(state), 0);
        tick(1);
        chk("R2 detect latency", 32'(state), 1);
        chk("R9 stamp", pf_stamp, 32'(cyc - 1));
        chk("R3 ingest closed", 32'(ingest_en), 0);
        pf_n = 1'b1;
        tick(1);
        chk("R3 freeze", 32'(state), 2);
        tick(1);
        chk("R3 flush", 32'(state), 3);
        chk("R4 freeze_seq", 32'(freeze_seq), 25);
        chk("R5 drain_req", 32'(drain_req), 1);
        cur_seq = 16'd31; commit_done = 1'b1;
        tick(1);
        commit_done = 1'b0;
        chk("R8 done ignored in flush", 32'(last_commit_seq), 10);
        chk("R4 freeze_seq held", 32'(freeze_seq), 25);
        chk("R5 still flushing", 32'(state), 3);
        tick(2);
        buf_empty = 1'b1;
        tick(1);
        chk("R3 commit", 32'(state), 4);
        chk("R6 commit_req", 32'(commit_req), 1);
        chk("R5 drain dropped", 32'(drain_req), 0);
        chk("R5 t_flush", 32'(t_flush), 4);
        tick(2);
        commit_done = 1'b1;
        tick(1);
        commit_done = 1'b0;
        chk("R3 recover", 32'(state), 5);
        chk("R6 last_commit_seq", 32'(last_commit_seq), 25);
        chk("R6 t_commit", 32'(t_commit), 3);
        chk("R7 no miss", 32'(commit_missed), 0);
        tick(5);
        chk("R10 state held", 32'(state), 5);
        chk("R10 latch held", 32'(pf_latched), 1);
        chk("R10 ingest stays closed", 32'(ingest_en), 0);
    endtask

    task automatic t_deadline_miss();
        bit seen = 0;
        do_reset();
        routine_commit(16'd7);
        cur_seq = 16'd9;
        pf_n = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            tick(1);
            if (state == 3'd1) seen = 1;
        end
        chk("R7 reached detect", 32'(seen), 1);
        tick(DL - 1);
        chk("R7 still flushing before deadline", 32'(state), 3);
        chk("R7 no miss yet", 32'(commit_missed), 0);
        tick(1);
        chk("R7 recover at deadline", 32'(state), 5);
        chk("R7 missed flag", 32'(commit_missed), 1);
        chk("R7 rollback point", 32'(last_commit_seq), 7);
        chk("R7 drain dropped", 32'(drain_req), 0);
        chk("R7 t_flush", 32'(t_flush), DL - 2);
        chk("R7 t_commit", 32'(t_commit), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_glitch_reject();
        t_full_sequence();
        t_deadline_miss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule